// File: doc/BRIEF.md
# Lockable Serial Number Register Bank

This block holds a 64-bit serial number as eight byte-wide registers on a simple register bus, where each cycle carries at most one access. While the bank is open, the host may write the serial bytes as often as it likes, so they also serve as general-purpose storage. A separate lock register guards the bank, and its top bit is a one-way latch. When the host writes that bit to 1, the serial bytes become read-only from the next cycle on. Nothing the host writes can clear the latch again. Only a reset returns the bank to its default state.

Reads are combinational from the address and need no select. They return the stored serial bytes whether or not the bank is locked. When the host tries to write a serial byte while the bank is locked, the write is dropped. The block then raises a one-cycle rejection strobe, so that the surrounding logic or a bench can see that the write was refused. Addresses outside the bank read as zero and ignore writes.

Top module: `snLockBank`

## Requirements
- R1: After reset, all eight serial bytes (addresses 10h to 17h) read 00h, the lock register (18h) reads 00h, and `wrReject` is low.
- R2: While unlocked, a write (`busSel`=1, `busWr`=1) to address 10h+i stores `busWdata` in byte i, readable from the next cycle. Repeated writes to the same byte each replace the previous value.
- R3: A write to 18h with bit 7 set locks the bank, and 18h reads 80h from the next cycle on.
- R4: While locked, writes to 10h to 17h leave every serial byte unchanged.
- R5: Once set, the lock stays set. A write of 00h to 18h does not clear it.
- R6: Bits 6:0 of 18h always read 0. A write to 18h with bit 7 clear leaves the bank unlocked.
- R7: Serial bytes read back their stored values while the bank is locked.
- R8: `wrReject` is high for exactly the cycle after each write attempt to a serial byte while locked. It is low after unlocked writes, after writes to 18h, after writes to other addresses, and in idle cycles.
- R9: Addresses outside 10h to 18h read 00h, and writes to them change no register. A write with `busSel`=0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Access valid this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Register address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for `busAddr` (combinational) |
| wrReject | output | 1 | One-cycle pulse after a rejected serial-byte write |

## Verification
The byte writes are tried with three data patterns:
- A walking pattern with a distinct value per byte shows whether the address decode sends each write to the right byte.
- Repeated rewrites of one byte show whether the bank stays rewritable while it is open.
- Writes just outside the window (0Fh and 19h) show whether the boundary decode is correct.

The lock register is written with three values:
- 7Fh checks that bits 6:0 neither lock the bank nor read back.
- FFh checks that the lock is set and that the status reads 80h.
- 00h afterwards checks that the lock is sticky.

After locking, the bench writes to the bytes again. Back-to-back rejected writes followed by an idle cycle show whether the rejection strobe is a true one-cycle pulse per attempt, and whether the contents survive.

// File: rtl/snBankPkg.sv
package snBankPkg;
  localparam int SN_IDX_W = 8;

  typedef struct packed {
    logic                wrByte;   // commit write of one serial byte
    logic                setLock;  // latch the lock
    logic                rdSn;     // read selects a serial byte
    logic                rdLock;   // read selects the lock register
    logic [SN_IDX_W-1:0] byteIdx;  // serial byte index for read/write
  } snStrobes_t;
endpackage

// File: rtl/snCtrl.sv
module snCtrl
  import snBankPkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          DATA_W    = 8,
  parameter int          NUM_BYTES = 8,
  parameter int unsigned BASE_ADDR = 'h10,
  parameter int          LOCK_BIT  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              lockQ,
  output snStrobes_t        strobes,
  output logic              wrReject
);
  localparam logic [ADDR_W-1:0] FIRST_A = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] LAST_A  = ADDR_W'(BASE_ADDR + NUM_BYTES - 1);
  localparam logic [ADDR_W-1:0] LOCK_A  = ADDR_W'(BASE_ADDR + NUM_BYTES);

  logic              inSn;
  logic              isLock;
  logic              wrAcc;
  logic              rejectNow;
  logic [ADDR_W-1:0] offset;

  always_comb begin
    inSn      = (busAddr >= FIRST_A) && (busAddr <= LAST_A);
    isLock    = (busAddr == LOCK_A);
    wrAcc     = busSel && busWr;
    offset    = busAddr - FIRST_A;
    rejectNow = wrAcc && inSn && lockQ;

    strobes.wrByte  = wrAcc && inSn && !lockQ;
    strobes.setLock = wrAcc && isLock && busWdata[LOCK_BIT];
    strobes.rdSn    = inSn;
    strobes.rdLock  = isLock;
    strobes.byteIdx = SN_IDX_W'(offset);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wrReject <= 1'b0;
    else       wrReject <= rejectNow;
  end

  // R8: a rejection pulse only ever follows a locked bank
  p_reject_needs_lock_r8: assert property (@(posedge clk) disable iff (!rstN)
    wrReject |-> lockQ);

  // R4: no byte write is committed while the bank is locked
  p_no_write_when_locked_r4: assert property (@(posedge clk) disable iff (!rstN)
    lockQ |-> !strobes.wrByte);

  // R2: one access per cycle, so the two write strobes never coincide
  p_single_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.wrByte, strobes.setLock}));
endmodule

// File: rtl/snData.sv
module snData
  import snBankPkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int NUM_BYTES = 8,
  parameter int LOCK_BIT  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  snStrobes_t        strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic              lockQ,
  output logic [DATA_W-1:0] rdData
);
  localparam int IDX_W = $clog2(NUM_BYTES);

  logic [NUM_BYTES-1:0][DATA_W-1:0] snMem;
  logic [IDX_W-1:0]                 idx;

  assign idx = strobes.byteIdx[IDX_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                lockQ <= 1'b0;
    else if (strobes.setLock) lockQ <= 1'b1;
  end

  for (genvar g = 0; g < NUM_BYTES; g++) begin : gByte
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        snMem[g] <= '0;
      else if (strobes.wrByte && (strobes.byteIdx == SN_IDX_W'(g)))
        snMem[g] <= wrData;
    end
  end

  always_comb begin
    rdData = '0;
    if (strobes.rdSn)        rdData = snMem[idx];
    else if (strobes.rdLock) rdData[LOCK_BIT] = lockQ;
  end

  // R5: the lock never falls once set
  p_lock_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    lockQ |=> lockQ);

  // R4: locked contents are frozen
  p_locked_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    (lockQ && $past(lockQ)) |-> $stable(snMem));

  // R2: a committed write lands in the addressed byte
  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrByte |=> (snMem[$past(idx)] == $past(wrData)));

  // R6: low bits of the lock register read as zero
  always_comb begin
    if (rstN && strobes.rdLock && !strobes.rdSn)
      p_lock_low_zero_r6: assert (rdData[LOCK_BIT-1:0] == '0);
  end
endmodule

// File: rtl/snLockBank.sv
module snLockBank
  import snBankPkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          DATA_W    = 8,
  parameter int          NUM_BYTES = 8,
  parameter int unsigned BASE_ADDR = 'h10,
  parameter int          LOCK_BIT  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              wrReject
);
  snStrobes_t strobes;
  logic       lockQ;

  snCtrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_BYTES(NUM_BYTES),
    .BASE_ADDR(BASE_ADDR), .LOCK_BIT(LOCK_BIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .lockQ(lockQ),
    .strobes(strobes), .wrReject(wrReject)
  );

  snData #(
    .DATA_W(DATA_W), .NUM_BYTES(NUM_BYTES), .LOCK_BIT(LOCK_BIT)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(busWdata),
    .lockQ(lockQ), .rdData(busRdata)
  );
endmodule

// File: tb/snLockBank_tb.sv
module snLockBank_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busSel = 1'b0;
  logic       busWr = 1'b0;
  logic [7:0] busAddr = 8'h00;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;
  logic       wrReject;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 1'b0;
  logic [7:0] expMem [8];

  always #10 clk = ~clk;

  snLockBank u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .wrReject(wrReject)
  );

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  // one write cycle; returns wrReject sampled in the following cycle
  task automatic wrReg(input logic [7:0] a, input logic [7:0] d,
                       input logic sel, output logic rej);
    @(negedge clk);
    busSel = sel; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
    rej = wrReject;
  endtask

  task automatic rdReg(input logic [7:0] a, output logic [7:0] d);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic checkAllBytes(input string req);
    logic [7:0] d;
    for (int i = 0; i < 8; i++) begin
      rdReg(8'h10 + 8'(i), d);
      check(req, $sformatf("byte %0d", i), d, expMem[i]);
    end
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int i = 0; i < 8; i++) expMem[i] = 8'h00;
    checkAllBytes("R1");
    rdReg(8'h18, d);
    check("R1", "lock reg", d, 8'h00);
    check("R1", "wrReject", {7'b0, wrReject}, 8'h00);
  endtask

  task automatic t_unlocked_rw();
    logic rej;
    for (int i = 0; i < 8; i++) begin
      wrReg(8'h10 + 8'(i), 8'hA0 + 8'(i * 3), 1'b1, rej);
      expMem[i] = 8'hA0 + 8'(i * 3);
      check("R8", "no reject unlocked", {7'b0, rej}, 8'h00);
    end
    checkAllBytes("R2");
    for (int k = 0; k < 4; k++) begin
      wrReg(8'h13, 8'h5A ^ 8'(k), 1'b1, rej);
      expMem[3] = 8'h5A ^ 8'(k);
    end
    checkAllBytes("R2");
  endtask

  task automatic t_lock_lowbits();
    logic rej;
    logic [7:0] d;
    wrReg(8'h18, 8'h7F, 1'b1, rej);
    check("R8", "no reject on lock reg", {7'b0, rej}, 8'h00);
    rdReg(8'h18, d);
    check("R6", "lock reg after 7Fh", d, 8'h00);
    wrReg(8'h16, 8'h3C, 1'b1, rej);
    expMem[6] = 8'h3C;
    checkAllBytes("R6");
  endtask

  task automatic t_out_of_range();
    logic rej;
    logic [7:0] d;
    wrReg(8'h0F, 8'hEE, 1'b1, rej);
    wrReg(8'h19, 8'hEE, 1'b1, rej);
    wrReg(8'h11, 8'hEE, 1'b0, rej);
    check("R9", "no reject out of range", {7'b0, rej}, 8'h00);
    rdReg(8'h0F, d); check("R9", "read 0Fh", d, 8'h00);
    rdReg(8'h19, d); check("R9", "read 19h", d, 8'h00);
    rdReg(8'h18, d); check("R9", "lock untouched", d, 8'h00);
    checkAllBytes("R9");
  endtask

  task automatic t_set_lock();
    logic rej;
    logic [7:0] d;
    wrReg(8'h18, 8'hFF, 1'b1, rej);
    check("R8", "no reject on lock set", {7'b0, rej}, 8'h00);
    rdReg(8'h18, d);
    check("R3", "lock reg after FFh", d, 8'h80);
  endtask

  task automatic t_locked_writes();
    logic [7:0] d;
    // back-to-back rejected writes, then idle
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = 8'h10; busWdata = 8'h11;
    @(negedge clk);
    check("R8", "reject pulse 1", {7'b0, wrReject}, 8'h01);
    busAddr = 8'h17; busWdata = 8'h22;
    @(negedge clk);
    check("R8", "reject pulse 2", {7'b0, wrReject}, 8'h01);
    busSel = 1'b0; busWr = 1'b0;
    @(negedge clk);
    check("R8", "reject ends", {7'b0, wrReject}, 8'h00);
    checkAllBytes("R4");
    checkAllBytes("R7");
    rdReg(8'h15, d);
    check("R7", "locked read 15h", d, expMem[5]);
  endtask

  task automatic t_lock_clear();
    logic rej;
    logic [7:0] d;
    wrReg(8'h18, 8'h00, 1'b1, rej);
    check("R8", "no reject on lock reg write", {7'b0, rej}, 8'h00);
    rdReg(8'h18, d);
    check("R5", "lock after 00h", d, 8'h80);
    wrReg(8'h12, 8'h99, 1'b1, rej);
    check("R5", "still rejecting", {7'b0, rej}, 8'h01);
    checkAllBytes("R5");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_unlocked_rw();
    t_lock_lowbits();
    t_out_of_range();
    t_set_lock();
    t_locked_writes();
    t_lock_clear();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule